// File: doc/BRIEF.md
# Wake-up Line Selector and Flags

This block watches a set of wake-up lines, each of which can be pointed at one of several candidate input signals. Every line has its own source selector, a polarity bit that picks rising or falling edge detection, and an enable. When an enabled line sees its active edge, a sticky status flag for that line is set. The OR of all set flags forms a single wake request. A power-mode sequencer uses that request to leave sleep, stop or standby.

Software programs the block over a small register bus with single-cycle writes and combinational reads. There are three configuration registers: enable, polarity and source select. Pending flags are read from a status register. To acknowledge them, software writes the value it read to a separate write-1-to-clear register. The candidate inputs are asynchronous and pass through a two-flop synchroniser. Any change to a line's configuration rebases that line's edge history, so reprogramming never produces a false edge.

Top module: `wkup_line_ctrl`

## Requirements
- R1: Each of the eight lines has an enable bit (bit l of the enable register, address 0). A write to the enable register changes only the enable bits. A line whose enable bit is clear never sets its flag.
- R2: Bit l of the polarity register (address 1) selects the active edge of line l: 0 means rising, 1 means falling.
- R3: Bits [2l+1:2l] of the select register (address 2) hold a source index s for line l. Line l then watches input bit `wk_src_i[4*l+s]`, and the other candidates of that line have no effect.
- R4: An active edge on an enabled line sets bit l of the status register (address 3). An input change made between two clock edges shows in the status register after the third following rising clock edge.
- R5: Writing to the clear register (address 4) clears every flag whose data bit is 1. Zero bits leave their flags unchanged. Reads of address 4 return 0.
- R6: The status register is read-only. A write to address 3 changes no flag.
- R7: `wake_req_o` is high exactly when at least one status flag is set. It falls only after a write to the clear register.
- R8: A write that changes a line's enable, polarity or source rebases that line's edge history. The change itself never sets the line's flag, even when the watched level flips because of it.
- R9: If an edge on a line and a clear of the same line land in the same cycle, the flag stays set.
- R10: After reset every register reads 0 and `wake_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address (0 enable, 1 polarity, 2 select, 3 status, 4 clear) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Combinational read data for bus_addr_i |
| wk_src_i | input | 32 | Candidate inputs, four per line, line l at bits [4l+3:4l] |
| wake_req_o | output | 1 | OR of all set status flags |

## Verification
The bench aims at the cycle in which a flag appears. A design that dropped or added a synchroniser stage would show its flag one cycle off. Polarity and source are reprogrammed on a line that is already enabled while the watched level flips. A design that did not rebase its edge history would raise a flag that no input edge caused. A clear is timed to land in the same cycle as a new edge; if the clear wins, that edge is silently lost. Zero-valued clears, writes to the read-only status address, and toggles on unselected or disabled inputs are also applied, to catch decode and masking mistakes.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int          ADDR_W   = 3;
  localparam logic [2:0]  ADDR_EN  = 3'd0;
  localparam logic [2:0]  ADDR_POL = 3'd1;
  localparam logic [2:0]  ADDR_SEL = 3'd2;
  localparam logic [2:0]  ADDR_STS = 3'd3;
  localparam logic [2:0]  ADDR_CLR = 3'd4;
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/wkup_regs.sv
module wkup_regs
  import wkup_pkg::*;
#(
  parameter int LINES = 8,
  parameter int SEL_W = 2,
  localparam int DW   = LINES * SEL_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [LINES-1:0]       en_o,
  output logic [LINES-1:0]       pol_o,
  output logic [LINES*SEL_W-1:0] sel_o,
  output logic [LINES-1:0]       clr_o,
  output logic [LINES-1:0]       chg_o
);
  logic [LINES-1:0]       en_q, en_d, pol_q, pol_d;
  logic [LINES*SEL_W-1:0] sel_q, sel_d;
  logic                   en_we, pol_we, sel_we;

  assign en_we  = wr_i && (addr_i == ADDR_EN);
  assign pol_we = wr_i && (addr_i == ADDR_POL);
  assign sel_we = wr_i && (addr_i == ADDR_SEL);

  always_comb begin
    en_d  = en_we  ? wdata_i[LINES-1:0] : en_q;
    pol_d = pol_we ? wdata_i[LINES-1:0] : pol_q;
    sel_d = sel_we ? wdata_i[LINES*SEL_W-1:0] : sel_q;
    for (int l = 0; l < LINES; l++) begin
      chg_o[l] = (en_d[l] != en_q[l]) || (pol_d[l] != pol_q[l]) ||
                 (sel_d[l*SEL_W +: SEL_W] != sel_q[l*SEL_W +: SEL_W]);
    end
    clr_o = (wr_i && (addr_i == ADDR_CLR)) ? wdata_i[LINES-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pol_q <= '0;
      sel_q <= '0;
    end else begin
      if (en_we)  en_q  <= en_d;
      if (pol_we) pol_q <= pol_d;
      if (sel_we) sel_q <= sel_d;
    end
  end

  assign en_o  = en_q;
  assign pol_o = pol_q;
  assign sel_o = sel_q;

  // R1: writes to other registers leave the enables alone
  assert_en_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADDR_EN) |=> $stable(en_q));
endmodule

// File: rtl/wkup_line.sv
module wkup_line #(
  parameter int NSRC  = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  src_i,
  input  logic             en_i,
  input  logic             pol_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             chg_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic level_w, edge_w;
  logic prev_q, chg_q, flag_q;
  logic flag_d;

  assign level_w = src_i[sel_i] ^ pol_i;
  assign edge_w  = en_i && level_w && !prev_q && !chg_q;

  always_comb begin
    flag_d = flag_q;
    if (clr_i)  flag_d = 1'b0;
    if (edge_w) flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      chg_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= level_w;
      chg_q  <= chg_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  assert_clr_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && edge_w) |=> flag_q);
  assert_clr_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !edge_w) |=> !flag_q);
  assert_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !flag_q) |=> !flag_q);
  assert_no_false_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |=> !$rose(flag_q));
endmodule

// File: rtl/wkup_line_ctrl.sv
module wkup_line_ctrl
  import wkup_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int NUM_SRC   = 4,
  localparam int SEL_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int DATA_W   = NUM_LINES * SEL_W,
  localparam int SRC_W    = NUM_LINES * NUM_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [SRC_W-1:0]  wk_src_i,
  output logic              wake_req_o
);
  logic [SRC_W-1:0]           src_sync;
  logic [NUM_LINES-1:0]       en, pol, clr, chg, status;
  logic [NUM_LINES*SEL_W-1:0] sel;

  wkup_sync #(.W(SRC_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wk_src_i),
    .q_o   (src_sync)
  );

  wkup_regs #(.LINES(NUM_LINES), .SEL_W(SEL_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (bus_wr_i),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i),
    .en_o   (en),
    .pol_o  (pol),
    .sel_o  (sel),
    .clr_o  (clr),
    .chg_o  (chg)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    wkup_line #(.NSRC(NUM_SRC), .SEL_W(SEL_W)) u_line (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .src_i (src_sync[l*NUM_SRC +: NUM_SRC]),
      .en_i  (en[l]),
      .pol_i (pol[l]),
      .sel_i (sel[l*SEL_W +: SEL_W]),
      .chg_i (chg[l]),
      .clr_i (clr[l]),
      .flag_o(status[l])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_EN:  bus_rdata_o[NUM_LINES-1:0] = en;
      ADDR_POL: bus_rdata_o[NUM_LINES-1:0] = pol;
      ADDR_SEL: bus_rdata_o = sel;
      ADDR_STS: bus_rdata_o[NUM_LINES-1:0] = status;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign wake_req_o = |status;

  assert_req_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wake_req_o) |-> $past(bus_wr_i && bus_addr_i == ADDR_CLR));
  assert_status_ro_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == ADDR_STS) |=> (($past(status) & ~status) == '0));
endmodule

// File: tb/wkup_line_ctrl_test.sv
`timescale 1ns/1ps
module wkup_line_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [31:0] src;
  logic        wake;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  wkup_line_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .wk_src_i(src), .wake_req_o(wake)
  );

  // behavioural reference
  logic [31:0] m_s1, m_s2;
  logic [7:0]  m_en, m_pol, m_flag, m_prev, m_chg;
  logic [15:0] m_sel;

  always @(posedge clk or negedge rst_n) begin : model
    logic [7:0]  nf, np, nc, ne, npol;
    logic [15:0] ns;
    logic        lvl;
    int          s;
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_en <= '0; m_pol <= '0; m_flag <= '0;
      m_prev <= '0; m_chg <= '0; m_sel <= '0;
    end else begin
      ne = m_en; npol = m_pol; ns = m_sel;
      if (wr && addr == 3'd0) ne = wdata[7:0];
      if (wr && addr == 3'd1) npol = wdata[7:0];
      if (wr && addr == 3'd2) ns = wdata;
      nf = m_flag;
      for (int l = 0; l < 8; l++) begin
        s = int'(m_sel[2*l +: 2]);
        lvl = m_s2[4*l + s] ^ m_pol[l];
        np[l] = lvl;
        if (wr && addr == 3'd4 && wdata[l]) nf[l] = 1'b0;
        if (m_en[l] && lvl && !m_prev[l] && !m_chg[l]) nf[l] = 1'b1;
        nc[l] = (ne[l] != m_en[l]) || (npol[l] != m_pol[l]) ||
                (ns[2*l +: 2] != m_sel[2*l +: 2]);
      end
      m_s1 <= src; m_s2 <= m_s1;
      m_en <= ne; m_pol <= npol; m_sel <= ns;
      m_flag <= nf; m_prev <= np; m_chg <= nc;
    end
  end

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {8'h00, m_en};
      3'd1: return {8'h00, m_pol};
      3'd2: return m_sel;
      3'd3: return {8'h00, m_flag};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R4/R7 wake", {31'd0, wake}, {31'd0, |m_flag});
      check("R1/R2/R3/R4/R5 rdata", {16'd0, rdata}, {16'd0, exp_rd(addr)});
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; addr = 3'd3; wdata = '0;
  endtask

  task automatic read_chk(input string req, input logic [2:0] a, input logic [15:0] e);
    @(negedge clk); addr = a; #1;
    check(req, {16'd0, rdata}, {16'd0, e});
    @(negedge clk); addr = 3'd3;
  endtask

  task automatic sts_chk(input string req, input logic [7:0] e);
    #1; check(req, {24'd0, rdata[7:0]}, {24'd0, e});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr = 1'b0; addr = 3'd3; wdata = '0; src = '0;
    idle(3);
    rst_n = 1'b1;
    // R10 reset state
    read_chk("R10 en", 3'd0, 16'h0);
    read_chk("R10 pol", 3'd1, 16'h0);
    read_chk("R10 sel", 3'd2, 16'h0);
    read_chk("R10 status", 3'd3, 16'h0);
    #1; check("R10 wake", {31'd0, wake}, 32'd0);

    // R4 rising edge on line 0, latency of three edges
    bus_write(3'd0, 16'h0001);
    idle(3);
    @(negedge clk); src[0] = 1'b1;
    tick(); tick();
    check("R4 not yet", {24'd0, rdata[7:0]}, 32'h0);
    tick();
    check("R4 flag set", {24'd0, rdata[7:0]}, 32'h1);
    check("R7 wake high", {31'd0, wake}, 32'd1);

    // R5 zero clear no effect, then clear
    bus_write(3'd4, 16'h0000); sts_chk("R5 zero clear", 8'h01);
    bus_write(3'd4, 16'h0001); sts_chk("R5 cleared", 8'h00);
    check("R7 wake low", {31'd0, wake}, 32'd0);

    // R2/R3 falling edge on line 1 via source 2 (input bit 6)
    bus_write(3'd1, 16'h0002);
    bus_write(3'd2, 16'h0008);
    @(negedge clk); src[6] = 1'b1; src[4] = 1'b1;
    idle(4);
    bus_write(3'd0, 16'h0003);
    idle(4); sts_chk("R8 enable no edge", 8'h00);
    @(negedge clk); src[4] = 1'b0;
    idle(4); sts_chk("R3 unselected ignored", 8'h00);
    @(negedge clk); src[6] = 1'b0;
    idle(4); sts_chk("R2 falling edge", 8'h02);

    // R1 disabled line 2 ignored
    @(negedge clk); src[8] = 1'b1;
    idle(4); sts_chk("R1 disabled ignored", 8'h02);
    bus_write(3'd4, 16'h0002); sts_chk("R5 clear line1", 8'h00);

    // R8 reconfiguring an enabled line
    @(negedge clk); src[13] = 1'b1;
    bus_write(3'd0, 16'h000B);
    idle(4); sts_chk("R8 enable line3", 8'h00);
    bus_write(3'd1, 16'h000A);
    idle(4); sts_chk("R8 polarity flip", 8'h00);
    bus_write(3'd1, 16'h0002);
    bus_write(3'd2, 16'h0048);
    idle(4); sts_chk("R8 source change", 8'h00);
    @(negedge clk); src[13] = 1'b0;
    idle(4);
    @(negedge clk); src[13] = 1'b1;
    idle(4); sts_chk("R4 line3 real edge", 8'h08);

    // R9 edge and clear in the same cycle
    bus_write(3'd4, 16'h00FF);
    @(negedge clk); src[0] = 1'b0;
    idle(4);
    @(negedge clk); src[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr = 1'b1; addr = 3'd4; wdata = 16'h0001;
    @(negedge clk); wr = 1'b0; addr = 3'd3; wdata = '0;
    sts_chk("R9 edge wins", 8'h01);

    // R6 status read-only
    bus_write(3'd3, 16'h0000); sts_chk("R6 status write ignored", 8'h01);

    // R7 several flags
    @(negedge clk); src[13] = 1'b0;
    idle(4);
    @(negedge clk); src[13] = 1'b1;
    idle(4); sts_chk("R7 two flags", 8'h09);
    bus_write(3'd4, 16'h0001);
    #1; check("R7 wake stays", {31'd0, wake}, 32'd1);
    bus_write(3'd4, 16'h0008);
    #1; check("R7 wake drops", {31'd0, wake}, 32'd0);

    read_chk("R5 clear reads 0", 3'd4, 16'h0);
    read_chk("R1 enable value", 3'd0, 16'h000B);
    read_chk("R2 polarity value", 3'd1, 16'h0002);
    read_chk("R3 select value", 3'd2, 16'h0048);

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule